// File: doc/BRIEF.md
# Push-Pull PWM Steering Controller

This block is the digital core of a push-pull pulse-width modulator. A free-running ramp counter climbs from zero to full scale, wraps to zero and starts a new period. Two comparisons are made against the ramp in every cycle. The first uses a dead-time threshold, which is a fixed built-in offset raised by a dead-time word. The second uses a duty command, which is the larger of a voltage-loop error word and a current-limit error word. Either comparison being true blanks the outputs. The drive pulses therefore fill the part of each period after the ramp has passed both levels, and they end when the ramp wraps.

A toggle flip-flop changes state on every rising edge of the blanking signal and steers alternate pulses to the two drive outputs. In push-pull mode the outputs take turns, so each runs at half the ramp frequency and the two never overlap. In single-ended mode the steering is disabled, and both outputs pulse together in every period. A one-cycle strobe marks each ramp restart.

Top module: `ppwm_steering_top`

## Requirements
- R1: The ramp period is 2^RAMP_W cycles (256 by default). `cycle_start_o` is high for exactly the one cycle in which the ramp value is zero, once per period.
- R2: While `rst_n` is low, `drive_a_o`, `drive_b_o` and `cycle_start_o` are all low. The first strobe appears in the first cycle after reset is released.
- R3: At ramp position p, both drive outputs are low whenever the duty command is greater than p. A pulse therefore runs from the later of the two thresholds up to the last position of the period, 2^RAMP_W-1. A duty command of 2^RAMP_W-1 leaves a one-cycle pulse.
- R4: The duty command is the larger of `volt_err_i` and `curr_err_i`. A current-limit word above the voltage word shortens the pulse.
- R5: The dead-time threshold is floor(3*2^RAMP_W/100) + `dead_i` (7 + `dead_i` by default). Both outputs are low while p is below this threshold, even with both error words at zero.
- R6: The dead-time threshold saturates at 2^RAMP_W. At saturation both outputs stay low for the whole period, and the steering flip-flop does not change state at the next restart.
- R7: With `push_pull_i`=1, each period's pulse goes to exactly one output. The output alternates at each period in which the blanking signal fell. The first period after reset drives B, and the two outputs are never high together.
- R8: With `push_pull_i`=0, both outputs carry the same pulse in every period.
- R9: Both outputs are low in the cycle with ramp value zero, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| volt_err_i | input | RAMP_W | Voltage-loop error level |
| curr_err_i | input | RAMP_W | Current-limit error level |
| dead_i | input | RAMP_W | Extra dead time added to the built-in offset |
| push_pull_i | input | 1 | 1: push-pull steering, 0: both outputs in parallel |
| drive_a_o | output | 1 | Drive output A |
| drive_b_o | output | 1 | Drive output B |
| cycle_start_o | output | 1 | One-cycle strobe at each ramp restart |

## Verification
The hardest case to reach is a period in which the blanking signal never falls. With no falling edge, the steering flip-flop skips a toggle, and the A/B alternation shifts by one period. The bench reaches this case by setting the dead-time word so high that the threshold saturates for two consecutive periods. It then returns to normal duty and checks which output the next pulse lands on. Inputs change only during the restart cycle, when blanking is guaranteed, so the expected value of every cycle can be predicted exactly.

// File: rtl/ppwm_pkg.sv
// Shared types for the push-pull PWM steering block.
package ppwm_pkg;
    typedef enum logic {
        DRV_PARALLEL = 1'b0,
        DRV_ALTERNATE = 1'b1
    } drv_mode_e;
endpackage

// File: rtl/ppwm_ramp.sv
// Free-running ramp counter.
// Holds at zero for one cycle after reset, then wraps every 2^W cycles.
// Assumes: synchronous active-low reset.
module ppwm_ramp #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] ramp,
    output logic         armed
);
    // Advance the ramp once armed; arm on the first clock after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ramp  <= '0;
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
            if (armed) ramp <= ramp + 1'b1;
        end
    end
endmodule

// File: rtl/ppwm_blank.sv
// Dead-time and PWM comparators, combined into one blanking signal.
// Assumes: dead_thr saturates at 2^W, so full blanking is reachable.
module ppwm_blank #(
    parameter int W       = 8,
    parameter int MIN_OFS = 7
) (
    input  logic [W-1:0] ramp,
    input  logic [W-1:0] volt_err,
    input  logic [W-1:0] curr_err,
    input  logic [W-1:0] dead,
    output logic         blank
);
    localparam logic [W:0] FULL = (W+1)'(2**W);
    localparam logic [W:0] OFS  = (W+1)'(MIN_OFS);

    logic [W:0]   thr_sum;
    logic [W:0]   dead_thr;
    logic [W-1:0] duty_cmd;
    logic         dt_cmp;
    logic         pwm_cmp;

    // Form the saturated dead-time threshold and the larger error.
    always_comb begin
        thr_sum  = {1'b0, dead} + OFS;
        dead_thr = (thr_sum > FULL) ? FULL : thr_sum;
        duty_cmd = (volt_err > curr_err) ? volt_err : curr_err;
        dt_cmp   = dead_thr > {1'b0, ramp};
        pwm_cmp  = duty_cmd > ramp;
        blank    = dt_cmp | pwm_cmp;
    end
endmodule

// File: rtl/ppwm_steer.sv
// Toggle flip-flop and output gating.
// Each drive is the NOR of blanking with its mode-gated phase.
// Assumes: blank is high at ramp zero, so phase changes only while outputs are blanked.
module ppwm_steer
    import ppwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      armed,
    input  logic      blank,
    input  drv_mode_e mode,
    output logic      phase,
    output logic      drv_a,
    output logic      drv_b
);
    logic blank_q;
    logic gate_a;
    logic gate_b;

    // Toggle the phase on each rising edge of blanking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank_q <= 1'b0;
            phase   <= 1'b0;
        end else begin
            blank_q <= armed & blank;
            if (armed && blank && !blank_q) phase <= ~phase;
        end
    end

    // Gate the phases with the mode and NOR them with blanking.
    always_comb begin
        gate_a = phase  & (mode == DRV_ALTERNATE);
        gate_b = ~phase & (mode == DRV_ALTERNATE);
        drv_a  = armed & ~(blank | gate_a);
        drv_b  = armed & ~(blank | gate_b);
    end
endmodule

// File: rtl/ppwm_steering_top.sv
// Push-pull PWM steering controller top.
// The ramp, the comparators and the steering logic are joined here.
// Assumes: inputs are synchronous to clk.
module ppwm_steering_top
    import ppwm_pkg::*;
#(
    parameter int RAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAMP_W-1:0] volt_err_i,
    input  logic [RAMP_W-1:0] curr_err_i,
    input  logic [RAMP_W-1:0] dead_i,
    input  logic              push_pull_i,
    output logic              drive_a_o,
    output logic              drive_b_o,
    output logic              cycle_start_o
);
    localparam int MIN_OFS = (3 * (2**RAMP_W)) / 100;

    logic [RAMP_W-1:0] ramp;
    logic              armed;
    logic              blank;
    logic              phase;
    drv_mode_e         mode;

    assign mode          = drv_mode_e'(push_pull_i);
    assign cycle_start_o = armed && (ramp == '0);

    ppwm_ramp #(.W(RAMP_W)) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .ramp  (ramp),
        .armed (armed)
    );

    ppwm_blank #(.W(RAMP_W), .MIN_OFS(MIN_OFS)) u_blank (
        .ramp     (ramp),
        .volt_err (volt_err_i),
        .curr_err (curr_err_i),
        .dead     (dead_i),
        .blank    (blank)
    );

    ppwm_steer u_steer (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (armed),
        .blank (blank),
        .mode  (mode),
        .phase (phase),
        .drv_a (drive_a_o),
        .drv_b (drive_b_o)
    );
endmodule

// File: rtl/ppwm_chk.sv
// Property checker for the steering controller, bound to the top.
module ppwm_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         armed,
    input logic         blank,
    input logic         phase,
    input logic [W-1:0] ramp,
    input logic         push_pull,
    input logic         drv_a,
    input logic         drv_b,
    input logic         start
);
    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_pull |-> !(drv_a && drv_b));

    // R3
    blank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (!drv_a && !drv_b));

    // R1
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!start && ramp == W'(1)));

    // R2
    unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (!drv_a && !drv_b && !start));

    // R6
    phase_on_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase) |-> $past(blank));

    // R9
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (!drv_a && !drv_b));
endmodule

bind ppwm_steering_top ppwm_chk #(.W(RAMP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (armed),
    .blank     (blank),
    .phase     (phase),
    .ramp      (ramp),
    .push_pull (push_pull_i),
    .drv_a     (drive_a_o),
    .drv_b     (drive_b_o),
    .start     (cycle_start_o)
);

// File: tb/tb_ppwm_steering_top.sv
// Scoreboard bench: the driver queues the expected outputs per cycle, and the monitor compares them.
module tb_ppwm_steering_top;
    localparam int W      = 8;
    localparam int PER    = 2**W;
    localparam int OFS    = (3 * PER) / 100;
    localparam int WD_LIM = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] volt_err = '0;
    logic [W-1:0] curr_err = '0;
    logic [W-1:0] dead = '0;
    logic         pp = 1'b1;
    logic         drv_a, drv_b, strobe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    // Bench-side steering model.
    bit m_phase = 0;
    bit m_first = 1;
    bit m_end_low = 0;

    always #2 clk = ~clk;

    ppwm_steering_top #(.RAMP_W(W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .volt_err_i    (volt_err),
        .curr_err_i    (curr_err),
        .dead_i        (dead),
        .push_pull_i   (pp),
        .drive_a_o     (drv_a),
        .drive_b_o     (drv_b),
        .cycle_start_o (strobe)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s t=%0t {strobe,a,b} actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // Monitor: compare each queued expectation at the falling edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {strobe, drv_a, drv_b}, e);
        end
    end

    // Driver: called in the strobe cycle. Sets the inputs and queues one period of expected values.
    task automatic run_period(input int ev, input int ei, input int dt, input bit mode, input string tag);
        int thr, err;
        bit blank;
        bit act;
        volt_err = W'(ev);
        curr_err = W'(ei);
        dead = W'(dt);
        pp = mode;
        thr = (OFS + dt > PER) ? PER : OFS + dt;
        err = (ev > ei) ? ev : ei;
        if (m_first || m_end_low) m_phase = ~m_phase;
        m_first = 0;
        for (int p = 0; p < PER; p++) begin
            blank = (p < thr) || (p < err);
            act = !blank;
            exp_q.push_back({p == 0, act && (mode ? !m_phase : 1'b1), act && (mode ? m_phase : 1'b1)});
            if (p == 0) tag_q.push_back({tag, "/R1/R9"});
            else tag_q.push_back(tag);
            if (p == PER - 1) m_end_low = !blank;
        end
        repeat (PER) @(posedge clk);
        #1;
    endtask

    initial begin
        // R2: all outputs stay low while reset is held.
        repeat (4) begin
            @(negedge clk);
            check("R2", {strobe, drv_a, drv_b}, 3'b000);
        end
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R2", {strobe, 2'b00}, 3'b100);
        run_period(60, 20, 0, 1'b1, "R3");
        run_period(60, 150, 0, 1'b1, "R4");
        run_period(100, 0, 0, 1'b1, "R7");
        run_period(0, 0, 0, 1'b1, "R5");
        run_period(30, 0, 100, 1'b1, "R5");
        run_period(30, 0, 255, 1'b1, "R6");
        run_period(0, 0, 250, 1'b1, "R6");
        run_period(40, 0, 0, 1'b1, "R6");
        run_period(80, 0, 0, 1'b0, "R8");
        run_period(0, 200, 0, 1'b0, "R8");
        run_period(255, 0, 0, 1'b1, "R3");
        run_period(10, 0, 0, 1'b1, "R7");
        run_period(10, 0, 0, 1'b1, "R7");
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WD_LIM) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule